// File: doc/BRIEF.md
# DRAM Row Column Bank Mapper

This block takes an address that is already local to one DRAM rank and splits it into the device coordinates used to open a page: the row, the column, the bank address and the bank group. The address bits are not taken as contiguous fields. Each output bit is picked from a fixed address position, and the set of positions depends on the page policy. A closed-page policy uses one set of positions and an open-page policy uses another.

Configuration arrives alongside each address and is treated as static by the caller:
- the page policy;
- a fine-grain bank mode;
- an enable for hashing the bank bits with higher address bits;
- the number of row bits the device has;
- the number of column bits the device has.

The mapping itself is combinational. It is followed by one register stage, which also carries a valid flag. A caller presents one address per cycle with `in_valid` and reads the result, marked by `out_valid`, one clock later.

Top module: `rcb_mapper`

## Requirements
- R1: In closed-page mode (`cfg_closed_page`=1), row bit i is the address bit at position i of the list 15,16,17,18,20,21,22,28,10,11,12,13,29,30,31,32,33.
- R2: In closed-page mode, column bit i (i<10) is taken from address position i of the list 3,4,5,14,19,23,24,25,26,27. Column bit 10 is always 1.
- R3: In open-page mode (`cfg_closed_page`=0), row bit i is the address bit at position i of the list 14,15,16,20,28,21,22,23,24,25,26,27,29,30,31,32,33.
- R4: In open-page mode, column bits 0..9 come from address bits 3..12 when `cfg_fine_bank`=0. They come from positions 3,4,5,7,8,9,10,11,12,13 when `cfg_fine_bank`=1. Column bit 10 is 0.
- R5: In closed-page mode, bank address is {a9,a8} and bank group is {a7,a6} (bit 1 first). When `cfg_bank_xor`=1 they are XORed with {a28,a22} and {a21,a20} respectively.
- R6: In open-page mode, bank address is {a19,a18}. When `cfg_bank_xor`=1 it is XORed with {a23,a22}.
- R7: In open-page mode, bank group is {a17,aG}, where G is 6 when `cfg_fine_bank`=1 and 13 otherwise. When `cfg_bank_xor`=1 it is XORed with {a21,a20}.
- R8: Row bits at or above `cfg_row_bits` are 0. A count of 17 or more keeps all 17 row bits.
- R9: Column bits 0..9 at or above `cfg_col_bits` are 0. A count of 10 or more keeps all ten gathered bits.
- R10: Outputs for an address accepted with `in_valid`=1 appear on the next clock edge, with `out_valid`=1. `out_valid` is 0 in the cycle after `in_valid`=0.
- R11: After a synchronous active-low reset all outputs are 0. In a cycle with `in_valid`=0 the row, column, bank and group outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Address and configuration are valid this cycle |
| rank_addr | input | 34 | Rank-local address |
| cfg_closed_page | input | 1 | 1 = closed-page policy, 0 = open-page policy |
| cfg_fine_bank | input | 1 | Fine-grain bank mode |
| cfg_bank_xor | input | 1 | Enable XOR hashing of bank address and bank group |
| cfg_row_bits | input | 5 | Number of row bits kept |
| cfg_col_bits | input | 4 | Number of column bits gathered |
| out_valid | output | 1 | Registered result valid |
| out_row | output | 17 | Row |
| out_col | output | 11 | Column, bit 10 = autoprecharge in closed-page mode |
| out_bank | output | 2 | Bank address |
| out_bgroup | output | 2 | Bank group |

## Verification
The embedded properties check several behaviours on every cycle:
- `out_valid` follows the one-cycle latency;
- column bit 10 depends only on the page policy;
- no row or column bit survives above the configured counts;
- the outputs hold in idle cycles.

Whether each bit was drawn from the correct scattered address position cannot be seen from such invariants. Nor can the effect of the XOR hash and of the fine-grain bank-group source. Those are shown by the bench's single-bit address walks, the directed XOR cases and randomised addresses, all compared with independently computed tables.

// File: rtl/rcb_pkg.sv
// Package: widths and bit-position tables shared by the mapper.
// Assumes rank-local addresses of at most ADDR_W bits; every table entry
// must be below ADDR_W.
package rcb_pkg;
    localparam int ADDR_W       = 34;
    localparam int ROW_W        = 17;
    localparam int COL_GATHER_W = 10;
    localparam int COL_W        = COL_GATHER_W + 1;
    localparam int AP_BIT       = COL_GATHER_W;
    localparam int ROW_CNT_W    = $clog2(ROW_W + 1);
    localparam int COL_CNT_W    = $clog2(COL_W);
    localparam int BANK_W       = 2;

    // Address position feeding each row / column bit, per policy.
    localparam int unsigned ROW_POS_CLOSED [ROW_W] =
        '{15, 16, 17, 18, 20, 21, 22, 28, 10, 11, 12, 13, 29, 30, 31, 32, 33};
    localparam int unsigned ROW_POS_OPEN [ROW_W] =
        '{14, 15, 16, 20, 28, 21, 22, 23, 24, 25, 26, 27, 29, 30, 31, 32, 33};
    localparam int unsigned COL_POS_CLOSED [COL_GATHER_W] =
        '{3, 4, 5, 14, 19, 23, 24, 25, 26, 27};
    localparam int unsigned COL_POS_OPEN [COL_GATHER_W] =
        '{3, 4, 5, 6, 7, 8, 9, 10, 11, 12};
    localparam int unsigned COL_POS_FINE [COL_GATHER_W] =
        '{3, 4, 5, 7, 8, 9, 10, 11, 12, 13};

    // Bank field sources: [0] = low bit position, [1] = high bit position.
    localparam int unsigned BA_CLOSED [BANK_W]     = '{8, 9};
    localparam int unsigned BA_CLOSED_XOR [BANK_W] = '{22, 28};
    localparam int unsigned BG_CLOSED [BANK_W]     = '{6, 7};
    localparam int unsigned BA_OPEN [BANK_W]       = '{18, 19};
    localparam int unsigned BA_OPEN_XOR [BANK_W]   = '{22, 23};
    localparam int unsigned BG_XOR [BANK_W]        = '{20, 21};
    localparam int unsigned BG_OPEN_HI             = 17;
    localparam int unsigned BG_OPEN_LO_FINE        = 6;
    localparam int unsigned BG_OPEN_LO_NORM        = 13;
endpackage

// File: rtl/rcb_row_gather.sv
// Row gather: picks each row bit from its policy-specific address position
// and clears the bits at or above the configured row count.
// Assumes row_bits is stable for the address presented.
module rcb_row_gather
    import rcb_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 closed_page,
    input  logic [ROW_CNT_W-1:0] row_bits,
    output logic [ROW_W-1:0]     row
);
    logic [ROW_W-1:0] closed_raw;
    logic [ROW_W-1:0] open_raw;
    logic [ROW_W-1:0] keep;

    // One gather lane per row bit, both policies in parallel.
    generate
        for (genvar i = 0; i < ROW_W; i++) begin : g_row
            assign closed_raw[i] = addr[ROW_POS_CLOSED[i]];
            assign open_raw[i]   = addr[ROW_POS_OPEN[i]];
            assign keep[i]       = (ROW_CNT_W'(i) < row_bits);
        end
    endgenerate

    // Policy select, then mask to the configured row width.
    always_comb begin
        row = (closed_page ? closed_raw : open_raw) & keep;
    end
endmodule

// File: rtl/rcb_col_gather.sv
// Column gather: picks ten column bits from one of three position tables
// (closed, open, open fine-grain), clears bits at or above the configured
// count and appends the autoprecharge bit, set only for closed page.
module rcb_col_gather
    import rcb_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 closed_page,
    input  logic                 fine_bank,
    input  logic [COL_CNT_W-1:0] col_bits,
    output logic [COL_W-1:0]     col
);
    logic [COL_GATHER_W-1:0] closed_raw;
    logic [COL_GATHER_W-1:0] open_raw;
    logic [COL_GATHER_W-1:0] fine_raw;
    logic [COL_GATHER_W-1:0] keep;
    logic [COL_GATHER_W-1:0] picked;

    // One gather lane per column bit for each table.
    generate
        for (genvar i = 0; i < COL_GATHER_W; i++) begin : g_col
            assign closed_raw[i] = addr[COL_POS_CLOSED[i]];
            assign open_raw[i]   = addr[COL_POS_OPEN[i]];
            assign fine_raw[i]   = addr[COL_POS_FINE[i]];
            assign keep[i]       = (COL_CNT_W'(i) < col_bits);
        end
    endgenerate

    // Table select by policy and bank mode.
    always_comb begin
        if (closed_page)    picked = closed_raw;
        else if (fine_bank) picked = fine_raw;
        else                picked = open_raw;
    end

    // Mask and attach the autoprecharge bit.
    always_comb begin
        col = {closed_page, picked & keep};
    end
endmodule

// File: rtl/rcb_bank_hash.sv
// Bank hash: forms bank address and bank group from policy-specific
// address bits and optionally XORs in higher address bits.
module rcb_bank_hash
    import rcb_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              closed_page,
    input  logic              fine_bank,
    input  logic              xor_en,
    output logic [BANK_W-1:0] bank,
    output logic [BANK_W-1:0] bgroup
);
    logic [BANK_W-1:0] ba_base;
    logic [BANK_W-1:0] ba_mix;
    logic [BANK_W-1:0] bg_base;
    logic [BANK_W-1:0] bg_mix;

    // Base and hash sources for the bank address.
    always_comb begin
        if (closed_page) begin
            ba_base = {addr[BA_CLOSED[1]], addr[BA_CLOSED[0]]};
            ba_mix  = {addr[BA_CLOSED_XOR[1]], addr[BA_CLOSED_XOR[0]]};
        end else begin
            ba_base = {addr[BA_OPEN[1]], addr[BA_OPEN[0]]};
            ba_mix  = {addr[BA_OPEN_XOR[1]], addr[BA_OPEN_XOR[0]]};
        end
    end

    // Base and hash sources for the bank group.
    always_comb begin
        if (closed_page)
            bg_base = {addr[BG_CLOSED[1]], addr[BG_CLOSED[0]]};
        else
            bg_base = {addr[BG_OPEN_HI],
                       fine_bank ? addr[BG_OPEN_LO_FINE] : addr[BG_OPEN_LO_NORM]};
        bg_mix = {addr[BG_XOR[1]], addr[BG_XOR[0]]};
    end

    // Apply the optional hash.
    always_comb begin
        bank   = ba_base ^ (xor_en ? ba_mix : '0);
        bgroup = bg_base ^ (xor_en ? bg_mix : '0);
    end
endmodule

// File: rtl/rcb_mapper.sv
// Top: maps a rank-local address to row, column, bank and bank group,
// registering the result one cycle after a valid input. Outputs hold
// while in_valid is low. Configuration is sampled with each address.
module rcb_mapper
    import rcb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [ADDR_W-1:0]    rank_addr,
    input  logic                 cfg_closed_page,
    input  logic                 cfg_fine_bank,
    input  logic                 cfg_bank_xor,
    input  logic [ROW_CNT_W-1:0] cfg_row_bits,
    input  logic [COL_CNT_W-1:0] cfg_col_bits,
    output logic                 out_valid,
    output logic [ROW_W-1:0]     out_row,
    output logic [COL_W-1:0]     out_col,
    output logic [BANK_W-1:0]    out_bank,
    output logic [BANK_W-1:0]    out_bgroup
);
    logic [ROW_W-1:0]  row_c;
    logic [COL_W-1:0]  col_c;
    logic [BANK_W-1:0] bank_c;
    logic [BANK_W-1:0] bg_c;

    rcb_row_gather u_row (
        .addr        (rank_addr),
        .closed_page (cfg_closed_page),
        .row_bits    (cfg_row_bits),
        .row         (row_c)
    );

    rcb_col_gather u_col (
        .addr        (rank_addr),
        .closed_page (cfg_closed_page),
        .fine_bank   (cfg_fine_bank),
        .col_bits    (cfg_col_bits),
        .col         (col_c)
    );

    rcb_bank_hash u_bank (
        .addr        (rank_addr),
        .closed_page (cfg_closed_page),
        .fine_bank   (cfg_fine_bank),
        .xor_en      (cfg_bank_xor),
        .bank        (bank_c),
        .bgroup      (bg_c)
    );

    // Valid pipeline flag.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result register, loaded only on a valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_row    <= '0;
            out_col    <= '0;
            out_bank   <= '0;
            out_bgroup <= '0;
        end else if (in_valid) begin
            out_row    <= row_c;
            out_col    <= col_c;
            out_bank   <= bank_c;
            out_bgroup <= bg_c;
        end
    end

    assert_valid_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_ap_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && cfg_closed_page |=> out_col[AP_BIT]);
    assert_ap_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !cfg_closed_page |=> !out_col[AP_BIT]);
    assert_row_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((out_row >> $past(cfg_row_bits)) == '0));
    assert_col_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((out_col[COL_GATHER_W-1:0] >> $past(cfg_col_bits)) == '0));
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_row) && $stable(out_col)
                      && $stable(out_bank) && $stable(out_bgroup));
endmodule

// File: tb/rcb_mapper_tb.sv
`timescale 1ns/1ps
module rcb_mapper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [33:0] rank_addr = '0;
    logic        cfg_closed_page = 1'b0;
    logic        cfg_fine_bank = 1'b0;
    logic        cfg_bank_xor = 1'b0;
    logic [4:0]  cfg_row_bits = '0;
    logic [3:0]  cfg_col_bits = '0;
    logic        out_valid;
    logic [16:0] out_row;
    logic [10:0] out_col;
    logic [1:0]  out_bank;
    logic [1:0]  out_bgroup;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int cr[17] = '{15,16,17,18,20,21,22,28,10,11,12,13,29,30,31,32,33};
    int orow[17] = '{14,15,16,20,28,21,22,23,24,25,26,27,29,30,31,32,33};
    int cc[10] = '{3,4,5,14,19,23,24,25,26,27};
    int fc[10] = '{3,4,5,7,8,9,10,11,12,13};

    always #2.5 clk = ~clk;

    rcb_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rank_addr(rank_addr),
        .cfg_closed_page(cfg_closed_page), .cfg_fine_bank(cfg_fine_bank),
        .cfg_bank_xor(cfg_bank_xor), .cfg_row_bits(cfg_row_bits),
        .cfg_col_bits(cfg_col_bits), .out_valid(out_valid), .out_row(out_row),
        .out_col(out_col), .out_bank(out_bank), .out_bgroup(out_bgroup)
    );

    function automatic logic [16:0] exp_row(logic [33:0] a, bit cp, int n);
        logic [16:0] r = '0;
        for (int i = 0; i < 17; i++)
            if (i < n) r[i] = cp ? a[cr[i]] : a[orow[i]];
        return r;
    endfunction

    function automatic logic [10:0] exp_col(logic [33:0] a, bit cp, bit fb, int n);
        logic [10:0] c = '0;
        for (int i = 0; i < 10; i++)
            if (i < n) c[i] = cp ? a[cc[i]] : (fb ? a[fc[i]] : a[i + 3]);
        c[10] = cp;
        return c;
    endfunction

    function automatic logic [1:0] exp_ba(logic [33:0] a, bit cp, bit x);
        logic [1:0] b;
        if (cp) b = {a[9], a[8]} ^ (x ? {a[28], a[22]} : 2'b00);
        else    b = {a[19], a[18]} ^ (x ? {a[23], a[22]} : 2'b00);
        return b;
    endfunction

    function automatic logic [1:0] exp_bg(logic [33:0] a, bit cp, bit fb, bit x);
        logic [1:0] g;
        if (cp) g = {a[7], a[6]};
        else    g = {a[17], fb ? a[6] : a[13]};
        return g ^ (x ? {a[21], a[20]} : 2'b00);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one valid vector and check the registered result.
    task automatic apply(logic [33:0] a, bit cp, bit fb, bit x, int rb, int cb);
        @(negedge clk);
        in_valid = 1'b1; rank_addr = a; cfg_closed_page = cp;
        cfg_fine_bank = fb; cfg_bank_xor = x;
        cfg_row_bits = 5'(rb); cfg_col_bits = 4'(cb);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 valid", 32'(out_valid), 32'd1);
        chk(cp ? (rb < 17 ? "R1/R8 row" : "R1 row") : (rb < 17 ? "R3/R8 row" : "R3 row"),
            32'(out_row), 32'(exp_row(a, cp, rb)));
        chk(cp ? "R2/R9 col" : "R4/R9 col", 32'(out_col), 32'(exp_col(a, cp, fb, cb)));
        chk(cp ? "R5 bank" : "R6 bank", 32'(out_bank), 32'(exp_ba(a, cp, x)));
        chk(cp ? "R5 bgroup" : "R7 bgroup", 32'(out_bgroup), 32'(exp_bg(a, cp, fb, x)));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [16:0] h_row;
        logic [10:0] h_col;
        logic [1:0]  h_ba;
        logic [1:0]  h_bg;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset valid", 32'(out_valid), 32'd0);
        chk("R11 reset row", 32'(out_row), 32'd0);
        chk("R11 reset col", 32'(out_col), 32'd0);
        chk("R11 reset bank", 32'({out_bank, out_bgroup}), 32'd0);

        // Single-bit walks in every mode, full widths, hash on and off.
        for (int p = 0; p < 34; p++) begin
            apply(34'd1 << p, 1'b1, 1'b0, 1'b0, 17, 10);
            apply(34'd1 << p, 1'b1, 1'b0, 1'b1, 17, 10);
            apply(34'd1 << p, 1'b0, 1'b0, 1'b1, 17, 10);
            apply(34'd1 << p, 1'b0, 1'b1, 1'b0, 17, 10);
            apply(34'd1 << p, 1'b0, 1'b1, 1'b1, 17, 10);
        end

        // Directed corners: zero counts, clamped counts, hash cancellation.
        apply('1, 1'b1, 1'b0, 1'b0, 0, 0);
        chk("R2 ap with zero columns", 32'(out_col), 32'h400);
        apply('1, 1'b0, 1'b0, 1'b0, 31, 15);
        chk("R8 clamp row", 32'(out_row), 32'h1FFFF);
        chk("R9 clamp col", 32'(out_col), 32'h3FF);
        apply(34'h3FFFFFFFF, 1'b0, 1'b1, 1'b1, 9, 4);
        apply((34'd1 << 22) | (34'd1 << 8), 1'b1, 1'b0, 1'b1, 17, 10);
        chk("R5 xor cancels", 32'(out_bank), 32'd0);
        apply((34'd1 << 13) | (34'd1 << 20), 1'b0, 1'b0, 1'b1, 17, 10);
        chk("R7 xor cancels", 32'(out_bgroup), 32'd0);

        // Hold check: idle cycle with new address must not change outputs.
        apply(34'h2_5A5A_A5A5, 1'b1, 1'b0, 1'b1, 15, 9);
        h_row = out_row; h_col = out_col; h_ba = out_bank; h_bg = out_bgroup;
        rank_addr = ~rank_addr; cfg_closed_page = 1'b0;
        @(negedge clk);
        chk("R10 idle valid", 32'(out_valid), 32'd0);
        chk("R11 hold row", 32'(out_row), 32'(h_row));
        chk("R11 hold col", 32'(out_col), 32'(h_col));
        chk("R11 hold bank", 32'({out_bank, out_bgroup}), 32'({h_ba, h_bg}));

        // Randomised vectors across all modes and counts.
        for (int n = 0; n < 400; n++) begin
            logic [33:0] a;
            a = {2'($urandom), 32'($urandom)};
            apply(a, 1'($urandom), 1'($urandom), 1'($urandom),
                  int'($urandom_range(0, 20)), int'($urandom_range(0, 12)));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule